// File: doc/BRIEF.md
# Serial 8-bit ADC Device-Side Emulator

This block stands in for the device end of a three-wire serial 8-bit analog-to-digital converter. A host controller under test drives an active-low chip select and a slow I/O clock. The block answers on a serial data line with the result it holds. The "analog" input is an 8-bit sample word supplied by the bench. A fast system clock synchronises the host's pins and times the internal conversion. No real converter is needed.

A read begins when chip select falls. The most significant bit of the held result appears with no I/O clock edge. Each following falling edge of the I/O clock brings out the next lower bit. The eighth falling edge captures the current sample word and starts a conversion. The conversion runs for a fixed number of ticks of a divided conversion clock. Its result is shown only on the next read, so every read returns the value captured by the read before it. If the host lowers chip select or moves the I/O clock while a conversion runs, a sticky protocol-error flag is set.

Two state machines do the work. The read machine has three states:
- RD_IDLE: chip select is high and the shift register tracks the stored result. It goes to RD_SHIFT when chip select is seen low.
- RD_SHIFT: each falling edge shifts one bit out. It goes to RD_HOLD on the eighth falling edge, which also starts a conversion. It goes back to RD_IDLE if chip select rises first.
- RD_HOLD: the eight bits are out and the line stays low. It goes to RD_IDLE when chip select rises.

The conversion machine has two states:
- CV_IDLE: waits for a start. It goes to CV_RUN on a start and captures the sample word.
- CV_RUN: counts conversion ticks. It goes back to CV_IDLE on the last tick and writes the captured word into the stored result.

Top module: `adc_serial_slave_model`

## Requirements
- R1: After reset the stored result is 0x00, no conversion is running, `sdo` is 0 and `proto_err` is 0. The first full read after reset therefore returns 0x00.
- R2: While chip select is high, `sdo` is 0. I/O clock edges seen while chip select is high move no bit pointer, so the next read still starts at bit 7 and returns the full value.
- R3: Within 3 system clocks of chip select falling, with no I/O clock edge, `sdo` shows bit 7 of the stored result.
- R4: Within 3 system clocks of the k-th falling edge of the I/O clock (k = 1 to 7) during a read, `sdo` shows bit 7-k of the stored result. Bits come out most significant first.
- R5: The eighth falling edge of a read captures `sample_in` and starts one conversion. The value shifted out by a read is the value captured by the previous full read.
- R6: A conversion lasts CONV_TICKS (36) ticks. One tick comes every SYS_CLK_HZ/CONV_CLK_HZ system clocks (12 by default). The stored result changes only when the last tick completes, and a read that starts after 36*12 + 40 system clocks sees the new value.
- R7: A read that ends, with chip select rising, before the eighth falling edge starts no conversion and leaves the stored result unchanged. The next read starts again at bit 7.
- R8: A falling chip select, or any I/O clock edge, seen while a conversion runs sets `proto_err`. The flag stays set until reset. The running conversion still completes with its captured word, and the stored result does not change before the conversion ends.
- R9: `cs_n` and `io_clk` each pass through two synchronising flip-flops. All their edges are taken from the synchronised copies.
- R10: After the eighth falling edge, and until chip select rises, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times synchronisation and conversion |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| io_clk | input | 1 | Serial I/O clock from the host |
| sample_in | input | 8 | Sample word converted on the eighth falling edge |
| sdo | output | 1 | Serial data line to the host, 0 when chip select is high |
| proto_err | output | 1 | Sticky flag for host activity during a conversion |

## Verification
The bench checks the one-read latency. A design that shows the sample of the current read, rather than the previous one, fails every chained comparison. Reads cut short after 0 to 7 falling edges must start no conversion; a design that counts a partial read as complete would replace the stored value. I/O clock toggling with chip select high must not move the bit pointer; a design that lets it would shift out a rotated byte. A read started early, during a conversion, must still show the old result and raise the sticky flag; a design that commits at once or clears the flag would show the wrong most significant bit or a low flag.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_HOLD  = 2'd2
    } rd_state_e;

    typedef enum logic {
        CV_IDLE = 1'b0,
        CV_RUN  = 1'b1
    } cv_state_e;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic lvl_prev
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {(STAGES + 1){RST_VAL}};
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign lvl      = pipe[STAGES-1];
    assign lvl_prev = pipe[STAGES];
endmodule

// File: rtl/adc_emu_tick.sv
module adc_emu_tick #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R6: ticks are spaced by the divider, never back to back
            assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/adc_emu_conv.sv
module adc_emu_conv
    import adc_emu_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CONV_TICKS = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] sample,
    output logic              busy,
    output logic [DATA_W-1:0] result
);
    localparam int TW = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
    localparam logic [TW-1:0] TLAST = TW'(CONV_TICKS - 1);

    cv_state_e         cv_q, cv_d;
    logic [TW-1:0]     tcnt;
    logic [DATA_W-1:0] held;
    logic [DATA_W-1:0] result_q;
    logic              last;

    assign last = (cv_q == CV_RUN) && tick && (tcnt == TLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cv_q <= CV_IDLE;
        else        cv_q <= cv_d;
    end

    always_comb begin
        cv_d = cv_q;
        unique case (cv_q)
            CV_IDLE: if (start) cv_d = CV_RUN;
            CV_RUN:  if (last)  cv_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            held     <= '0;
            result_q <= '0;
        end else begin
            if (cv_q == CV_IDLE && start) begin
                held <= sample;
                tcnt <= '0;
            end else if (cv_q == CV_RUN && tick) begin
                tcnt <= tcnt + TW'(1);
            end
            if (last) result_q <= held;
        end
    end

    always_comb begin
        busy   = (cv_q == CV_RUN);
        result = result_q;
    end

    // R5: a start while idle always begins a conversion
    assert_start_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R8: the stored result holds until the final tick of a running conversion
    assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(result));
    // R7: with no conversion running the stored result never moves
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(result));
    // R6: tick counter stays inside the conversion length
    assert_tick_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tcnt <= TLAST));
endmodule

// File: rtl/adc_serial_slave_model.sv
module adc_serial_slave_model
    import adc_emu_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 50_000_000,
    parameter int CONV_CLK_HZ = 4_000_000,
    parameter int DATA_W      = 8,
    parameter int CONV_TICKS  = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        io_clk,
    input  logic [7:0]  sample_in,
    output logic        sdo,
    output logic        proto_err
);
    localparam int DIV = (SYS_CLK_HZ / CONV_CLK_HZ > 0) ? SYS_CLK_HZ / CONV_CLK_HZ : 1;
    localparam int BW  = $clog2(DATA_W);
    localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

    logic cs_lvl, cs_prev, sck_lvl, sck_prev;
    logic cs_fall, sck_fall, sck_edge;
    logic tick, busy, conv_start;
    logic [DATA_W-1:0] result;
    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bcnt;
    logic              err_q;
    rd_state_e         rd_q, rd_d;

    // R9: two-stage synchronisers for the host pins
    adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n), .lvl(cs_lvl), .lvl_prev(cs_prev));
    adc_emu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .async_in(io_clk), .lvl(sck_lvl), .lvl_prev(sck_prev));

    assign cs_fall  = cs_prev & ~cs_lvl;
    assign sck_fall = sck_prev & ~sck_lvl;
    assign sck_edge = sck_prev ^ sck_lvl;

    adc_emu_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    adc_emu_conv #(.DATA_W(DATA_W), .CONV_TICKS(CONV_TICKS)) u_conv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(conv_start),
        .sample(sample_in[DATA_W-1:0]), .busy(busy), .result(result));

    assign conv_start = (rd_q == RD_SHIFT) && !cs_lvl && sck_fall && (bcnt == BLAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE:  if (!cs_lvl) rd_d = RD_SHIFT;
            RD_SHIFT: begin
                if (cs_lvl)          rd_d = RD_IDLE;
                else if (conv_start) rd_d = RD_HOLD;
            end
            RD_HOLD:  if (cs_lvl) rd_d = RD_IDLE;
            default:  rd_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bcnt  <= '0;
            err_q <= 1'b0;
        end else begin
            if (rd_q == RD_IDLE) begin
                shreg <= result;
                bcnt  <= '0;
            end else if (rd_q == RD_SHIFT && !cs_lvl && sck_fall) begin
                shreg <= {shreg[DATA_W-2:0], 1'b0};
                bcnt  <= bcnt + BW'(1);
            end
            if (busy && (cs_fall || sck_edge)) err_q <= 1'b1;
        end
    end

    always_comb begin
        sdo       = (rd_q == RD_IDLE) ? 1'b0 : shreg[DATA_W-1];
        proto_err = err_q;
    end

    // R8: the protocol flag is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R2: chip select high for two cycles keeps the line low
    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && $past(cs_lvl)) |-> !sdo);
    // R5: a started conversion moves the read machine into its hold state
    assert_start_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (rd_q == RD_HOLD));
    // R10: once in hold the line stays low
    assert_hold_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_HOLD && $past(rd_q) == RD_HOLD) |-> !sdo);
endmodule

// File: tb/tb_adc_serial_slave_model.sv
module tb_adc_serial_slave_model;
    localparam int HALF      = 25;
    localparam int CONV_WAIT = 36 * 12 + 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       io_clk = 1'b0;
    logic [7:0] sample_in = 8'h00;
    logic       sdo, proto_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    adc_serial_slave_model dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
        .sample_in(sample_in), .sdo(sdo), .proto_err(proto_err));

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] read_mask(input int nfalls);
        return 8'hFF << (7 - nfalls);
    endfunction

    // one read: MSB at chip-select fall, then nfalls falling edges
    task automatic do_read(input logic [7:0] smp, input int nfalls, output logic [7:0] got);
        got = 8'h00;
        sample_in = smp;
        cs_n = 1'b0;
        wait_cyc(6);
        got[7] = sdo;
        for (int i = 1; i <= nfalls; i++) begin
            io_clk = 1'b1;
            wait_cyc(HALF);
            io_clk = 1'b0;
            wait_cyc(HALF);
            if (i < 8) got[7-i] = sdo;
        end
        if (nfalls == 8) check("R10 line low after eighth edge", sdo, 1'b0);
        cs_n = 1'b1;
        wait_cyc(6);
        check("R2 line low with chip select high", sdo, 1'b0);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cs_n = 1'b1;
        io_clk = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] exp_res;
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);

        // R1 reset state
        do_reset();
        check("R1 sdo after reset", sdo, 1'b0);
        check("R1 proto_err after reset", proto_err, 1'b0);

        // R2 io_clk edges with chip select high are ignored
        for (int i = 0; i < 5; i++) begin
            io_clk = 1'b1; wait_cyc(7);
            io_clk = 1'b0; wait_cyc(7);
        end
        check("R2 sdo during idle toggling", sdo, 1'b0);

        // R1 R5 first read gives reset value
        do_read(8'hA5, 8, got);
        check("R1 first read returns zero", got, 8'h00);
        check("R2 no error from idle toggling", proto_err, 1'b0);
        wait_cyc(CONV_WAIT);

        // R3 R4 R5 previous sample comes out MSB first
        do_read(8'h3C, 8, got);
        check("R5 read returns previous sample", got, 8'hA5);
        wait_cyc(CONV_WAIT);

        // R7 partial read starts nothing
        do_read(8'hFF, 3, got);
        check("R7 partial read bits", got & read_mask(3), 8'h3C & read_mask(3));
        wait_cyc(CONV_WAIT);
        do_read(8'hC3, 8, got);
        check("R7 value kept after partial read", got, 8'h3C);
        wait_cyc(CONV_WAIT);

        // R6 conversion finished within the allowed wait
        do_read(8'h7E, 8, got);
        check("R6 converted value visible", got, 8'hC3);

        // R8 early chip select during conversion
        cs_n = 1'b0;
        wait_cyc(6);
        check("R8 old result MSB during conversion", sdo, 1'b1);
        check("R8 error flag on early select", proto_err, 1'b1);
        cs_n = 1'b1;
        wait_cyc(CONV_WAIT);
        do_read(8'h11, 8, got);
        check("R8 conversion still completes", got, 8'h7E);
        check("R8 flag sticky", proto_err, 1'b1);
        wait_cyc(CONV_WAIT);

        // R1 reset clears flag and result
        do_reset();
        check("R1 flag cleared by reset", proto_err, 1'b0);
        do_read(8'h5A, 8, got);
        check("R1 result cleared by reset", got, 8'h00);
        exp_res = 8'h5A;
        wait_cyc(CONV_WAIT);

        // random reads mixed with partial reads
        for (int n = 0; n < 24; n++) begin
            logic [7:0] smp;
            int nf;
            smp = 8'($urandom);
            if (($urandom % 4) == 0) begin
                nf = int'($urandom % 8);
                do_read(smp, nf, got);
                check("R7 random partial read", got & read_mask(nf), exp_res & read_mask(nf));
            end else begin
                do_read(smp, 8, got);
                check("R4 random full read", got, exp_res);
                exp_res = smp;
            end
            wait_cyc(CONV_WAIT);
        end
        check("R9 no error across clean traffic", proto_err, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule